// File: doc/BRIEF.md
# UART Interrupt Identification and Register Decode

This block is the interrupt section of a 16550-style serial controller. It owns the interrupt enable register, the line control register (for its divisor-latch access bit), the two divisor latch bytes and the scratch byte. From the enables and a handful of status inputs supplied by neighbouring logic (overrun, receive data present, modem status change, FIFO mode), it resolves the single highest-priority active cause. It presents that cause as the identification byte on a read of offset 2 and drives a level interrupt output.

A transmit-empty cause is modelled as a sticky pending flag rather than a live status bit. A write to the data register sets the flag, and so does turning the transmit-empty enable on. It clears only when an identification read actually reports it. Receive data is always reported with the character-timeout code. Data-register accesses are passed to neighbouring logic as single-cycle strobes. Offsets 4 to 6 belong to other blocks, so this block returns 0xFF for them.

Top module: `uart_irq_id`

## Requirements
- R1: Causes are ranked, highest first: overrun with IER bit 2 set (code 0x6), receive data present with IER bit 0 set, transmit-empty pending with IER bit 1 set (code 0x2), modem change with IER bit 3 set (code 0x0); with none active the code is 0x1.
- R2: A winning receive-data cause is reported with identification code 0xC.
- R3: Every write to offset 0 with LCR bit 7 clear sets the transmit-empty pending flag and pulses `tx_push` for that cycle.
- R4: A write to offset 1 (LCR bit 7 clear) that changes IER bit 1 from 0 to 1 sets the pending flag; a write that leaves it at 1 does not.
- R5: A read of offset 2 that reports code 0x2 clears the pending flag; a read that reports a higher-priority code leaves it set.
- R6: Writes to the IER keep only bits 3:0; bits 7:4 read back as 0.
- R7: The identification byte is {bits 7:6 = 11 if `fifo_en` else 00, bits 5:4 = 00, bits 3:0 = code}.
- R8: `irq` is high exactly when the resolved code is not 0x1, evaluated continuously from the registers and status inputs.
- R9: With LCR bit 7 set, offsets 0 and 1 read and write the low and high divisor bytes instead of data and IER; `divisor` shows {high, low}, and reset loads the value 1.
- R10: Offset 3 is the LCR and offset 7 is plain read/write storage; reads of offsets 4, 5 and 6 return 0xFF, and writes to them and to offset 2 change nothing.
- R11: After reset the IER, LCR and scratch hold 0, the pending flag is clear, `irq` is low and offset 2 reads 0x01.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | 3 | Register offset |
| wr_en | input | 1 | Write strobe for `addr` |
| wr_data | input | 8 | Write data |
| rd_en | input | 1 | Read strobe for `addr` (side effects taken at the clock edge) |
| rd_data | output | 8 | Combinational read value for `addr` |
| rx_byte | input | 8 | Receive byte from the receive buffer, returned on data reads |
| rx_pop | output | 1 | Data-register read strobe to the receive buffer |
| tx_push | output | 1 | Data-register write strobe to the transmitter (data on `wr_data`) |
| overrun | input | 1 | Overrun flag |
| rx_avail | input | 1 | Receive buffer not empty |
| modem_delta | input | 1 | Any modem status change bit set |
| fifo_en | input | 1 | FIFO mode enabled |
| divisor | output | 16 | Divisor latch value for the baud generator |
| irq | output | 1 | Interrupt request, active high |

## Verification
The checks take for granted that `wr_en` and `rd_en` are never high together. They also assume the status inputs are already stable when a read strobe is sampled, since the identification byte and the clear decision are taken from the same combinational cause. The stimulus changes inputs only on the falling edge, keeps each access to a single strobe, and compares `rd_data` and `irq` shortly after that edge, before the rising edge commits any side effect.

// File: rtl/uart_irq_id.sv
module uart_irq_id #(
  parameter logic [15:0] RESET_DIV = 16'd1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [2:0]  addr,
  input  logic        wr_en,
  input  logic [7:0]  wr_data,
  input  logic        rd_en,
  output logic [7:0]  rd_data,
  input  logic [7:0]  rx_byte,
  output logic        rx_pop,
  output logic        tx_push,
  input  logic        overrun,
  input  logic        rx_avail,
  input  logic        modem_delta,
  input  logic        fifo_en,
  output logic [15:0] divisor,
  output logic        irq
);
  localparam logic [2:0] OFS_DATA = 3'd0;
  localparam logic [2:0] OFS_IER  = 3'd1;
  localparam logic [2:0] OFS_IIR  = 3'd2;
  localparam logic [2:0] OFS_LCR  = 3'd3;
  localparam logic [2:0] OFS_SCR  = 3'd7;

  localparam logic [3:0] C_NONE  = 4'h1;
  localparam logic [3:0] C_LINE  = 4'h6;
  localparam logic [3:0] C_RXTO  = 4'hC;
  localparam logic [3:0] C_THRE  = 4'h2;
  localparam logic [3:0] C_MODEM = 4'h0;

  logic [3:0] ier_q;
  logic [7:0] lcr_q, scr_q, dll_q, dlh_q;
  logic       thre_pend;
  logic [3:0] cause;

  wire dlab     = lcr_q[7];
  wire hit_data = (addr == OFS_DATA) && !dlab;
  wire hit_dll  = (addr == OFS_DATA) &&  dlab;
  wire hit_ier  = (addr == OFS_IER)  && !dlab;
  wire hit_dlh  = (addr == OFS_IER)  &&  dlab;

  assign tx_push = wr_en && hit_data;
  assign rx_pop  = rd_en && hit_data;
  assign divisor = {dlh_q, dll_q};

  always_comb begin
    if (overrun && ier_q[2])          cause = C_LINE;
    else if (rx_avail && ier_q[0])    cause = C_RXTO;
    else if (thre_pend && ier_q[1])   cause = C_THRE;
    else if (modem_delta && ier_q[3]) cause = C_MODEM;
    else                              cause = C_NONE;
  end

  assign irq = (cause != C_NONE);

  wire [7:0] iir_byte = {{2{fifo_en}}, 2'b00, cause};
  wire thre_set = tx_push || (wr_en && hit_ier && !ier_q[1] && wr_data[1]);
  wire thre_clr = rd_en && (addr == OFS_IIR) && (cause == C_THRE);

  always_comb begin
    if (hit_dll)                 rd_data = dll_q;
    else if (hit_dlh)            rd_data = dlh_q;
    else begin
      case (addr)
        OFS_DATA: rd_data = rx_byte;
        OFS_IER:  rd_data = {4'h0, ier_q};
        OFS_IIR:  rd_data = iir_byte;
        OFS_LCR:  rd_data = lcr_q;
        OFS_SCR:  rd_data = scr_q;
        default:  rd_data = 8'hFF;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ier_q     <= '0;
      lcr_q     <= '0;
      scr_q     <= '0;
      dll_q     <= RESET_DIV[7:0];
      dlh_q     <= RESET_DIV[15:8];
      thre_pend <= 1'b0;
    end else begin
      if (wr_en) begin
        if (hit_dll)                  dll_q <= wr_data;
        if (hit_dlh)                  dlh_q <= wr_data;
        if (hit_ier)                  ier_q <= wr_data[3:0];
        if (addr == OFS_LCR)          lcr_q <= wr_data;
        if (addr == OFS_SCR)          scr_q <= wr_data;
      end
      if (thre_set)      thre_pend <= 1'b1;
      else if (thre_clr) thre_pend <= 1'b0;
    end
  end
endmodule

// File: rtl/uart_irq_id_chk.sv
module uart_irq_id_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [2:0] addr,
  input logic       wr_en,
  input logic       rd_en,
  input logic [7:0] rd_data,
  input logic       irq,
  input logic       overrun,
  input logic       fifo_en,
  input logic       tx_push,
  input logic [3:0] ier_q,
  input logic [7:0] lcr_q,
  input logic       thre_pend
);
  p_ier_nibble_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr == 3'd1 && !lcr_q[7]) |-> (rd_data[7:4] == 4'h0));

  p_iir_top_bits_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr == 3'd2) |-> (rd_data[7:6] == {2{fifo_en}} && rd_data[5:4] == 2'b00));

  p_irq_vs_code_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr == 3'd2) |-> (irq == (rd_data[3:0] != 4'h1)));

  p_line_first_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr == 3'd2 && overrun && ier_q[2]) |-> (rd_data[3:0] == 4'h6));

  p_push_sets_r3: assert property (@(posedge clk) disable iff (!rst_n)
    tx_push |=> thre_pend);

  p_read_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr == 3'd2 && rd_data[3:0] == 4'h2 && !wr_en) |=> !thre_pend);

  p_dlab_hides_data_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == 3'd0 && lcr_q[7]) |-> !tx_push);
endmodule

bind uart_irq_id uart_irq_id_chk u_chk (
  .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
  .rd_data(rd_data), .irq(irq), .overrun(overrun), .fifo_en(fifo_en),
  .tx_push(tx_push), .ier_q(ier_q), .lcr_q(lcr_q), .thre_pend(thre_pend)
);

// File: tb/uart_irq_id_bench.sv
module uart_irq_id_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [2:0] addr = '0;
  logic wr_en = 1'b0, rd_en = 1'b0;
  logic [7:0] wr_data = '0, rx_byte = 8'h3C;
  logic overrun = 1'b0, rx_avail = 1'b0, modem_delta = 1'b0, fifo_en = 1'b0;
  logic [7:0] rd_data;
  logic [15:0] divisor;
  logic rx_pop, tx_push, irq;
  int checks = 0, errors = 0;

  always #10 clk = ~clk;

  uart_irq_id u_uart_irq_id (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
    .rd_en(rd_en), .rd_data(rd_data), .rx_byte(rx_byte), .rx_pop(rx_pop),
    .tx_push(tx_push), .overrun(overrun), .rx_avail(rx_avail),
    .modem_delta(modem_delta), .fifo_en(fifo_en), .divisor(divisor), .irq(irq)
  );

  // op 0 write, 1 read+compare; status {overrun, rx_avail, modem_delta, fifo_en}
  localparam int NV = 26;
  localparam logic [24:0] VEC [NV] = '{
    {2'd1, 3'd2, 8'h00, 4'b0000, 8'h01},  // R11 idle id
    {2'd0, 3'd1, 8'hFF, 4'b0000, 8'h00},  // enable all, raises transmit enable
    {2'd1, 3'd1, 8'h00, 4'b0000, 8'h0F},  // R6
    {2'd1, 3'd2, 8'h00, 4'b1111, 8'hC6},  // R1 R7
    {2'd1, 3'd2, 8'h00, 4'b0110, 8'h0C},  // R2
    {2'd1, 3'd2, 8'h00, 4'b0010, 8'h02},  // R5 clears
    {2'd1, 3'd2, 8'h00, 4'b0010, 8'h00},  // R1 modem last
    {2'd1, 3'd2, 8'h00, 4'b0000, 8'h01},
    {2'd0, 3'd0, 8'h55, 4'b0000, 8'h00},  // R3 data write
    {2'd1, 3'd2, 8'h00, 4'b0001, 8'hC2},
    {2'd1, 3'd2, 8'h00, 4'b0001, 8'hC1},
    {2'd0, 3'd1, 8'h0F, 4'b0000, 8'h00},  // R4 no re-arm
    {2'd1, 3'd2, 8'h00, 4'b0000, 8'h01},
    {2'd0, 3'd3, 8'h80, 4'b0000, 8'h00},  // R9 latch access on
    {2'd1, 3'd0, 8'h00, 4'b0000, 8'h01},  // R9 reset divisor low
    {2'd0, 3'd0, 8'h34, 4'b0000, 8'h00},
    {2'd0, 3'd1, 8'h12, 4'b0000, 8'h00},
    {2'd1, 3'd1, 8'h00, 4'b0000, 8'h12},
    {2'd0, 3'd3, 8'h03, 4'b0000, 8'h00},
    {2'd1, 3'd3, 8'h00, 4'b0000, 8'h03},  // R10 lcr
    {2'd1, 3'd1, 8'h00, 4'b0000, 8'h0F},  // R9 IER untouched
    {2'd1, 3'd2, 8'h00, 4'b0000, 8'h01},  // R9 latch write did not arm
    {2'd0, 3'd7, 8'hA5, 4'b0000, 8'h00},
    {2'd1, 3'd7, 8'h00, 4'b0000, 8'hA5},  // R10 scratch
    {2'd1, 3'd5, 8'h00, 4'b0000, 8'hFF},  // R10 unowned
    {2'd1, 3'd0, 8'h00, 4'b0000, 8'h3C}   // data read returns rx byte
  };

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic access(input logic is_rd, input logic [2:0] a, input logic [7:0] d,
                        input logic [3:0] st);
    @(negedge clk);
    addr = a; wr_data = d; rd_en = is_rd; wr_en = !is_rd;
    {overrun, rx_avail, modem_delta, fifo_en} = st;
    #1;
  endtask

  task automatic idle();
    @(negedge clk);
    wr_en = 1'b0; rd_en = 1'b0;
  endtask

  initial begin
    #2000000;
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    #1;
    check("R11 irq", {15'd0, irq}, 16'd0);
    check("R11 divisor", divisor, 16'h0001);

    for (int i = 0; i < NV; i++) begin
      access(VEC[i][23] , VEC[i][22:20], VEC[i][19:12], VEC[i][11:8]);
      if (VEC[i][24:23] == 2'd1) begin
        check($sformatf("vector %0d (R1..R11 set)", i), {8'h0, rd_data}, {8'h0, VEC[i][7:0]});
        if (VEC[i][22:20] == 3'd2)
          check($sformatf("R8 irq at vector %0d", i), {15'd0, irq}, {15'd0, VEC[i][3:0] != 4'h1});
      end
      if (i == 8) check("R3 tx_push", {15'd0, tx_push}, 16'd1);
      if (i == 25) check("rx_pop", {15'd0, rx_pop}, 16'd1);
    end
    idle(); #1;
    check("R9 divisor out", divisor, 16'h1234);

    // R4: enable 0 -> 1 arms the pending flag
    access(1'b0, 3'd1, 8'h00, 4'b0000);
    access(1'b0, 3'd1, 8'h02, 4'b0000);
    access(1'b1, 3'd2, 8'h00, 4'b0000);
    check("R4 rising enable", {8'h0, rd_data}, 16'h0002);

    // R5: higher cause leaves the flag set
    access(1'b0, 3'd1, 8'h06, 4'b0000);
    access(1'b0, 3'd0, 8'h11, 4'b0000);
    access(1'b1, 3'd2, 8'h00, 4'b1000);
    check("R5 line wins", {8'h0, rd_data}, 16'h0006);
    access(1'b1, 3'd2, 8'h00, 4'b0000);
    check("R5 still pending", {8'h0, rd_data}, 16'h0002);

    // R8: level follows status without a read
    access(1'b0, 3'd1, 8'h01, 4'b0000);
    idle(); rx_avail = 1'b1; #1;
    check("R8 irq high", {15'd0, irq}, 16'd1);
    rx_avail = 1'b0; #1;
    check("R8 irq low", {15'd0, irq}, 16'd0);

    // R10: writes to offsets 2 and 5 alter nothing
    access(1'b0, 3'd2, 8'hFF, 4'b0000);
    access(1'b0, 3'd5, 8'h00, 4'b0000);
    access(1'b1, 3'd1, 8'h00, 4'b0000);
    check("R10 ier kept", {8'h0, rd_data}, 16'h0001);
    access(1'b1, 3'd2, 8'h00, 4'b0000);
    check("R10 id kept", {8'h0, rd_data}, 16'h0001);
    idle();

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule